// File: doc/BRIEF.md
# Polynomial Operand Staging Port

This block is the processor-side front end of a polynomial ring accelerator. It is a 64-bit memory-mapped slave that software reaches with plain loads and stores. Software fills an operand window with the coefficients of up to `2*K_MAX` polynomials of 256 coefficients each. Each 64-bit word carries four 16-bit coefficient lanes. Every lane is reduced modulo 3329 on entry and kept as a 12-bit value in a local buffer. The compute core fetches this buffer word by word through its own read port.

Software starts a job by writing the command register. It then polls the status register. The core writes the result polynomial into a separate result buffer, and software reads that buffer back through the result window. Coefficients therefore cross the bus only twice: as operands before a job and as the result after it. While a job runs, software cannot disturb the operands, and the core cannot overwrite results once the job has finished.

Top module: `poly_stage_if`

## Requirements
- R1: After reset the job is idle with done clear, `core_start` is low, and a status read returns 0.
- R2: A write to an operand word stores each 16-bit lane j (bits 16j+15..16j) reduced modulo 3329. Reading that word back returns each reduced value zero-extended in the same lane.
- R3: Operand word w (0..2*K_MAX*64-1) sits at byte offset 0x100+8w. Core read index w returns the four reduced 12-bit coefficients, lane j in bits 12j+11..12j, one cycle after `core_rd_en`.
- R4: Writing offset 0x000 with bit0=1 while idle sets busy and clears done. It drives `core_start` high for exactly the next cycle and latches bits[2:1] as `core_k`, which holds until the next accepted start. A command read returns the latched value in bits[2:1] with bit0 zero.
- R5: A start command written while busy is ignored: no new `core_start` pulse, and `core_k` does not change.
- R6: Status at offset 0x008 reports busy in bit0 and done in bit1. A `core_done` pulse while busy clears busy and sets done. Busy and done are never both set.
- R7: Operand-window writes made while busy leave the stored operand unchanged.
- R8: Result word w (0..63) reads at byte offset 0x2000+8w and returns what the core wrote to index w, lanes zero-extended. The core's writes are accepted only while busy. Bus writes to the result window are dropped.
- R9: A misaligned address, or any address outside the command, status, operand and result locations, reads as zero. A write to such an address changes no stored state. A bus write to the status offset is also dropped.
- R10: Bus read data appears in the cycle after `bus_rd_en` and is zero in every cycle that follows no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_wr_addr | input | ADDR_W | Bus write byte address |
| bus_wr_data | input | 64 | Bus write data |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_rd_addr | input | ADDR_W | Bus read byte address |
| bus_rd_data | output | 64 | Bus read data, one cycle after the strobe |
| core_start | output | 1 | One-cycle job start pulse to the core |
| core_k | output | 2 | Latched command field for the core |
| core_done | input | 1 | Job completion pulse from the core |
| core_rd_en | input | 1 | Core operand read strobe |
| core_rd_idx | input | log2(2*K_MAX*64) | Core operand word index |
| core_rd_data | output | 48 | Four reduced 12-bit coefficients |
| core_wr_en | input | 1 | Core result write strobe |
| core_wr_idx | input | log2(64) | Core result word index |
| core_wr_data | input | 48 | Four 12-bit result coefficients |

## Verification
Directed lane values of 0, 3328, 3329 and 65535 separate a correct modulo reduction from plain truncation and from a single conditional subtraction. Random 64-bit words spread over the whole operand window, including its first and last word, expose lane-order and address-offset mistakes in both the bus path and the core path. Writes and start commands issued while a job runs, core writes issued after it ends, and accesses to misaligned and unmapped offsets each show whether the relevant guard is present, because they compare the stored state before and after the access. A second start after completion shows that done is cleared.

// File: rtl/pstg_pkg.sv
package pstg_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 16;
    localparam int COEF_W  = 12;
    localparam int BUS_W   = LANES * LANE_W;
    localparam int STORE_W = LANES * COEF_W;
    localparam int MODQ    = 3329;
    localparam int CMD_OFS  = 0;
    localparam int STAT_OFS = 8;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_CMD,
        RGN_STAT,
        RGN_OPND,
        RGN_RES
    } region_e;

    typedef struct packed {
        region_e     rgn;
        logic [15:0] idx;
    } dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } run_e;

    // Binary restoring reduction: any 16-bit value is below 32*MODQ.
    function automatic logic [COEF_W-1:0] lane_reduce(input logic [LANE_W-1:0] v);
        logic [LANE_W:0] r;
        r = {1'b0, v};
        for (int s = 4; s >= 0; s--) begin
            if (r >= (LANE_W+1)'(MODQ << s))
                r = r - (LANE_W+1)'(MODQ << s);
        end
        return r[COEF_W-1:0];
    endfunction

endpackage

// File: rtl/pstg_decode.sv
module pstg_decode import pstg_pkg::*; #(
    parameter int ADDR_W     = 14,
    parameter int OPND_BASE  = 32'h100,
    parameter int OPND_WORDS = 512,
    parameter int RES_BASE   = 32'h2000,
    parameter int RES_WORDS  = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam logic [31:0] OP_LO  = 32'(OPND_BASE);
    localparam logic [31:0] OP_HI  = 32'(OPND_BASE + OPND_WORDS * 8);
    localparam logic [31:0] RS_LO  = 32'(RES_BASE);
    localparam logic [31:0] RS_HI  = 32'(RES_BASE + RES_WORDS * 8);
    localparam logic [31:0] CMD_A  = 32'(CMD_OFS);
    localparam logic [31:0] STAT_A = 32'(STAT_OFS);

    logic [31:0] a_ext;
    assign a_ext = 32'(addr);

    always_comb begin
        dec.rgn = RGN_NONE;
        dec.idx = '0;
        if (a_ext[2:0] == 3'b000) begin
            if (a_ext == CMD_A) begin
                dec.rgn = RGN_CMD;
            end else if (a_ext == STAT_A) begin
                dec.rgn = RGN_STAT;
            end else if (a_ext >= OP_LO && a_ext < OP_HI) begin
                dec.rgn = RGN_OPND;
                dec.idx = 16'((a_ext - OP_LO) >> 3);
            end else if (a_ext >= RS_LO && a_ext < RS_HI) begin
                dec.rgn = RGN_RES;
                dec.idx = 16'((a_ext - RS_LO) >> 3);
            end
        end
    end

endmodule

// File: rtl/pstg_ctrl.sv
module pstg_ctrl import pstg_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [2:0] cmd_bits,
    input  logic       core_done,
    output logic       busy,
    output logic       done,
    output logic [1:0] k_q,
    output logic       core_start
);

    run_e state;

    assign busy = (state == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            done       <= 1'b0;
            k_q        <= '0;
            core_start <= 1'b0;
        end else begin
            core_start <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_wr && cmd_bits[0]) begin
                        state      <= ST_RUN;
                        done       <= 1'b0;
                        k_q        <= cmd_bits[2:1];
                        core_start <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (core_done) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pstg_buffer.sv
module pstg_buffer import pstg_pkg::*; #(
    parameter int OPND_WORDS = 512,
    parameter int RES_WORDS  = 64,
    localparam int OPND_IW   = $clog2(OPND_WORDS),
    localparam int RES_IW    = $clog2(RES_WORDS)
) (
    input  logic               clk,
    input  logic               op_we,
    input  logic [OPND_IW-1:0] op_widx,
    input  logic [BUS_W-1:0]   op_wdata,
    input  logic [OPND_IW-1:0] op_ridx,
    output logic [BUS_W-1:0]   op_rdata,
    input  logic [RES_IW-1:0]  res_ridx,
    output logic [BUS_W-1:0]   res_rdata,
    input  logic               core_rd_en,
    input  logic [OPND_IW-1:0] core_rd_idx,
    output logic [STORE_W-1:0] core_rd_data,
    input  logic               core_wr_en,
    input  logic [RES_IW-1:0]  core_wr_idx,
    input  logic [STORE_W-1:0] core_wr_data
);

    logic [STORE_W-1:0] op_mem  [OPND_WORDS];
    logic [STORE_W-1:0] res_mem [RES_WORDS];
    logic [STORE_W-1:0] packed_w;
    logic [STORE_W-1:0] op_word;
    logic [STORE_W-1:0] res_word;

    assign op_word  = op_mem[op_ridx];
    assign res_word = res_mem[res_ridx];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign packed_w[j*COEF_W +: COEF_W]  = lane_reduce(op_wdata[j*LANE_W +: LANE_W]);
        assign op_rdata[j*LANE_W +: LANE_W]  = {{(LANE_W-COEF_W){1'b0}}, op_word[j*COEF_W +: COEF_W]};
        assign res_rdata[j*LANE_W +: LANE_W] = {{(LANE_W-COEF_W){1'b0}}, res_word[j*COEF_W +: COEF_W]};
    end

    always_ff @(posedge clk) begin
        if (op_we)
            op_mem[op_widx] <= packed_w;
    end

    always_ff @(posedge clk) begin
        if (core_wr_en)
            res_mem[core_wr_idx] <= core_wr_data;
    end

    always_ff @(posedge clk) begin
        if (core_rd_en)
            core_rd_data <= op_mem[core_rd_idx];
    end

endmodule

// File: rtl/poly_stage_if.sv
module poly_stage_if import pstg_pkg::*; #(
    parameter int K_MAX     = 4,
    parameter int N_COEF    = 256,
    parameter int ADDR_W    = 14,
    parameter int OPND_BASE = 32'h100,
    parameter int RES_BASE  = 32'h2000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr_en,
    input  logic [ADDR_W-1:0]   bus_wr_addr,
    input  logic [63:0]         bus_wr_data,
    input  logic                bus_rd_en,
    input  logic [ADDR_W-1:0]   bus_rd_addr,
    output logic [63:0]         bus_rd_data,
    output logic                core_start,
    output logic [1:0]          core_k,
    input  logic                core_done,
    input  logic                core_rd_en,
    input  logic [$clog2(2*K_MAX*N_COEF/pstg_pkg::LANES)-1:0] core_rd_idx,
    output logic [pstg_pkg::STORE_W-1:0] core_rd_data,
    input  logic                core_wr_en,
    input  logic [$clog2(N_COEF/pstg_pkg::LANES)-1:0] core_wr_idx,
    input  logic [pstg_pkg::STORE_W-1:0] core_wr_data
);

    localparam int OPND_WORDS = 2 * K_MAX * N_COEF / LANES;
    localparam int RES_WORDS  = N_COEF / LANES;
    localparam int OPND_IW    = $clog2(OPND_WORDS);
    localparam int RES_IW     = $clog2(RES_WORDS);

    dec_t             wr_dec;
    dec_t             rd_dec;
    logic             busy;
    logic             done;
    logic [1:0]       k_q;
    logic             cmd_wr;
    logic             op_we;
    logic             res_we;
    logic [BUS_W-1:0] op_rdata;
    logic [BUS_W-1:0] res_rdata;
    logic [BUS_W-1:0] rd_mux;

    pstg_decode #(
        .ADDR_W    (ADDR_W),
        .OPND_BASE (OPND_BASE),
        .OPND_WORDS(OPND_WORDS),
        .RES_BASE  (RES_BASE),
        .RES_WORDS (RES_WORDS)
    ) i_wdec (
        .addr(bus_wr_addr),
        .dec (wr_dec)
    );

    pstg_decode #(
        .ADDR_W    (ADDR_W),
        .OPND_BASE (OPND_BASE),
        .OPND_WORDS(OPND_WORDS),
        .RES_BASE  (RES_BASE),
        .RES_WORDS (RES_WORDS)
    ) i_rdec (
        .addr(bus_rd_addr),
        .dec (rd_dec)
    );

    assign cmd_wr = bus_wr_en && (wr_dec.rgn == RGN_CMD);
    assign op_we  = bus_wr_en && (wr_dec.rgn == RGN_OPND) && !busy;
    assign res_we = core_wr_en && busy;

    pstg_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_bits  (bus_wr_data[2:0]),
        .core_done (core_done),
        .busy      (busy),
        .done      (done),
        .k_q       (k_q),
        .core_start(core_start)
    );

    assign core_k = k_q;

    pstg_buffer #(
        .OPND_WORDS(OPND_WORDS),
        .RES_WORDS (RES_WORDS)
    ) i_buf (
        .clk         (clk),
        .op_we       (op_we),
        .op_widx     (wr_dec.idx[OPND_IW-1:0]),
        .op_wdata    (bus_wr_data),
        .op_ridx     (rd_dec.idx[OPND_IW-1:0]),
        .op_rdata    (op_rdata),
        .res_ridx    (rd_dec.idx[RES_IW-1:0]),
        .res_rdata   (res_rdata),
        .core_rd_en  (core_rd_en),
        .core_rd_idx (core_rd_idx),
        .core_rd_data(core_rd_data),
        .core_wr_en  (res_we),
        .core_wr_idx (core_wr_idx),
        .core_wr_data(core_wr_data)
    );

    always_comb begin
        case (rd_dec.rgn)
            RGN_CMD:  rd_mux = {{(BUS_W-3){1'b0}}, k_q, 1'b0};
            RGN_STAT: rd_mux = {{(BUS_W-2){1'b0}}, done, busy};
            RGN_OPND: rd_mux = op_rdata;
            RGN_RES:  rd_mux = res_rdata;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rd_data <= '0;
        else if (bus_rd_en)
            bus_rd_data <= rd_mux;
        else
            bus_rd_data <= '0;
    end

endmodule

// File: rtl/pstg_check.sv
module pstg_check (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        core_start,
    input logic        core_done,
    input logic [1:0]  core_k,
    input logic        bus_rd_en,
    input logic [63:0] bus_rd_data
);

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start) else $error("start pulse too long"); // R4

    AST_START_STATE: assert property (@(posedge clk) disable iff (rst)
        core_start |-> (busy && !done)) else $error("start without busy"); // R4

    AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> core_start) else $error("busy rose without start"); // R5

    AST_K_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !core_done) |=> $stable(core_k)) else $error("k changed in job"); // R5

    AST_DONE_ENDS_JOB: assert property (@(posedge clk) disable iff (rst)
        (busy && core_done) |=> (!busy && done)) else $error("done not taken"); // R6

    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)) else $error("busy and done together"); // R6

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |=> (bus_rd_data == 64'd0)) else $error("read data leaked"); // R10

endmodule

bind poly_stage_if pstg_check i_pstg_check (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .core_start (core_start),
    .core_done  (core_done),
    .core_k     (core_k),
    .bus_rd_en  (bus_rd_en),
    .bus_rd_data(bus_rd_data)
);

// File: tb/test_poly_stage_if.sv
module test_poly_stage_if;

    localparam int NOPW = 512;
    localparam int NRSW = 64;
    localparam logic [13:0] OPB = 14'h100;
    localparam logic [13:0] RSB = 14'h2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [13:0] bus_wr_addr = '0;
    logic [63:0] bus_wr_data = '0;
    logic        bus_rd_en = 1'b0;
    logic [13:0] bus_rd_addr = '0;
    logic [63:0] bus_rd_data;
    logic        core_start;
    logic [1:0]  core_k;
    logic        core_done = 1'b0;
    logic        core_rd_en = 1'b0;
    logic [8:0]  core_rd_idx = '0;
    logic [47:0] core_rd_data;
    logic        core_wr_en = 1'b0;
    logic [5:0]  core_wr_idx = '0;
    logic [47:0] core_wr_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] exp_op [NOPW];
    logic [47:0] exp_rs [NRSW];
    int          widx [40];
    logic [63:0] rv;
    int unsigned seed_v;

    always #5 clk = ~clk;

    poly_stage_if i_poly_stage_if (
        .clk(clk), .rst(rst),
        .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
        .bus_rd_en(bus_rd_en), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
        .core_start(core_start), .core_k(core_k), .core_done(core_done),
        .core_rd_en(core_rd_en), .core_rd_idx(core_rd_idx), .core_rd_data(core_rd_data),
        .core_wr_en(core_wr_en), .core_wr_idx(core_wr_idx), .core_wr_data(core_wr_data)
    );

    function automatic logic [63:0] ref_word(input logic [63:0] d);
        logic [63:0] r;
        for (int j = 0; j < 4; j++)
            r[j*16 +: 16] = 16'(32'(d[j*16 +: 16]) % 3329);
        return r;
    endfunction

    function automatic logic [47:0] ref_core(input logic [63:0] w);
        logic [47:0] r;
        for (int j = 0; j < 4; j++)
            r[j*12 +: 12] = w[j*16 +: 12];
        return r;
    endfunction

    function automatic logic [63:0] widen(input logic [47:0] c);
        logic [63:0] r;
        for (int j = 0; j < 4; j++)
            r[j*16 +: 16] = {4'b0, c[j*12 +: 12]};
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [13:0] a, input logic [63:0] d);
        bus_wr_en = 1'b1; bus_wr_addr = a; bus_wr_data = d;
        @(posedge clk); @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [13:0] a, output logic [63:0] d);
        bus_rd_en = 1'b1; bus_rd_addr = a;
        @(posedge clk); @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rd_data;
    endtask

    task automatic core_rd(input int w, output logic [47:0] d);
        core_rd_en = 1'b1; core_rd_idx = 9'(w);
        @(posedge clk); @(negedge clk);
        core_rd_en = 1'b0;
        d = core_rd_data;
    endtask

    task automatic core_wr(input int w, input logic [47:0] d);
        core_wr_en = 1'b1; core_wr_idx = 6'(w); core_wr_data = d;
        @(posedge clk); @(negedge clk);
        core_wr_en = 1'b0;
    endtask

    task automatic pulse_done();
        core_done = 1'b1;
        @(posedge clk); @(negedge clk);
        core_done = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [47:0] cd;
        logic [63:0] d;
        seed_v = $urandom(32'h5eed_1234);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 core_start", {63'd0, core_start}, 64'd0);
        bus_rd(14'h008, rv); check("R1 status", rv, 64'd0);

        // R2 directed lane corners: 0, 3328, 3329, 65535
        d = {16'hFFFF, 16'd3329, 16'd3328, 16'd0};
        bus_wr(OPB, d); exp_op[0] = ref_word(d);
        bus_rd(OPB, rv); check("R2 corner lanes", rv, {16'd2284, 16'd0, 16'd3328, 16'd0});

        // R10 idle cycle after a read yields zero
        @(posedge clk); @(negedge clk);
        check("R10 idle read data", bus_rd_data, 64'd0);

        // R2 R3 random words over the window, including both ends
        for (int i = 0; i < 40; i++) begin
            widx[i] = (i == 0) ? 0 : (i == 1) ? NOPW - 1 : int'($urandom % NOPW);
            d = {$urandom, $urandom};
            bus_wr(OPB + 14'(widx[i] * 8), d);
            exp_op[widx[i]] = ref_word(d);
        end
        for (int i = 0; i < 40; i++) begin
            bus_rd(OPB + 14'(widx[i] * 8), rv);
            check("R2 random readback", rv, exp_op[widx[i]]);
        end
        for (int i = 0; i < 8; i++) begin
            core_rd(widx[i], cd);
            check("R3 core operand read", {16'd0, cd}, {16'd0, ref_core(exp_op[widx[i]])});
        end

        // R9 misaligned and unmapped accesses
        bus_rd(OPB + 14'd4, rv);  check("R9 misaligned read", rv, 64'd0);
        bus_rd(14'h1100, rv);     check("R9 past operand window", rv, 64'd0);
        bus_rd(14'h0010, rv);     check("R9 gap read", rv, 64'd0);
        bus_rd(14'h2200, rv);     check("R9 past result window", rv, 64'd0);
        bus_wr(OPB + 14'd4, 64'h0123_0456_0789_0abc);
        bus_rd(OPB, rv);          check("R9 misaligned write dropped", rv, exp_op[0]);
        bus_wr(14'h008, 64'h3);
        bus_rd(14'h008, rv);      check("R9 status write dropped", rv, 64'd0);

        // R4 accepted start
        bus_wr(14'h000, 64'h5);
        check("R4 start pulse", {63'd0, core_start}, 64'd1);
        check("R4 k latched", {62'd0, core_k}, 64'd2);
        @(posedge clk); @(negedge clk);
        check("R4 pulse one cycle", {63'd0, core_start}, 64'd0);
        bus_rd(14'h008, rv); check("R6 busy status", rv, 64'd1);
        bus_rd(14'h000, rv); check("R4 command readback", rv, 64'h4);

        // R5 start while busy
        bus_wr(14'h000, 64'h7);
        check("R5 no second pulse", {63'd0, core_start}, 64'd0);
        check("R5 k unchanged", {62'd0, core_k}, 64'd2);

        // R7 operand write while busy
        bus_wr(OPB + 14'(widx[2] * 8), 64'h0001_0002_0003_0004);
        bus_rd(OPB + 14'(widx[2] * 8), rv);
        check("R7 busy write dropped", rv, exp_op[widx[2]]);

        // R8 core fills result, bus writes dropped
        for (int w = 0; w < NRSW; w++) begin
            for (int j = 0; j < 4; j++) exp_rs[w][j*12 +: 12] = 12'($urandom % 3329);
            core_wr(w, exp_rs[w]);
        end
        bus_wr(RSB + 14'd8, 64'h0bad_0bad_0bad_0bad);

        // R6 completion
        pulse_done();
        bus_rd(14'h008, rv); check("R6 done status", rv, 64'd2);

        for (int w = 0; w < NRSW; w++) begin
            bus_rd(RSB + 14'(w * 8), rv);
            check("R8 result readback", rv, widen(exp_rs[w]));
        end

        // R8 core write after job end dropped
        core_wr(0, 48'h111_222_333_444);
        bus_rd(RSB, rv); check("R8 idle core write dropped", rv, widen(exp_rs[0]));

        // R4 new start clears done, new k
        bus_wr(14'h000, 64'h1);
        check("R4 restart pulse", {63'd0, core_start}, 64'd1);
        check("R4 restart k", {62'd0, core_k}, 64'd0);
        bus_rd(14'h008, rv); check("R4 done cleared", rv, 64'd1);
        pulse_done();
        bus_rd(14'h008, rv); check("R6 second done", rv, 64'd2);

        summary();
        $finish;
    end

endmodule